// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns supply-health information into a clean system reset for the logic around it. It watches three inputs:

- a synchronous flag, from an external comparator, that is high while the supply is above its reset threshold;
- a flag that is high once the supply is at least minimally valid;
- an active-low manual-reset request.

Reset is held during power-up. It is released only after the supply has stayed good for a programmable number of clock cycles.

A supply drop forces reset on the next clock edge, with no counting. Any new assert cause arriving while a reset pulse is running restarts the hold count from zero. A manual request is first brought into the clock domain. It then counts only if it stays low for a parameterised number of cycles, so short glitches are filtered out. After a qualified request is released, reset lasts one more full hold period.

Two outputs are provided: an active-low reset and an active-high reset. Each is driven by its own register. Analog comparison, hysteresis and pad behaviour live outside the block.

Top module: `supply_rst_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first clock after it, `rst_n_o` is 0 and `rst_o` is 1.
- R2: If `supply_ok_i` is 0 at a rising edge, `rst_n_o` is 0 after that edge, regardless of how far the hold count had progressed.
- R3: With `supply_min_i`=1, `man_rst_n_i`=1, and `supply_ok_i` high from edge 1 onward, `rst_n_o` rises after exactly edge HOLD_CYC.
- R4: A supply drop of one cycle during a running hold count restarts the count. Reset is then released exactly HOLD_CYC edges after `supply_ok_i` returns high.
- R5: If `man_rst_n_i` is held low for at least MR_QUAL_CYC edges, `rst_n_o` falls after edge MR_QUAL_CYC+3, counted from the first edge that samples it low.
- R6: A low pulse on `man_rst_n_i` lasting MR_QUAL_CYC-1 edges or fewer is ignored: `rst_n_o` stays high.
- R7: Once a qualified manual request is released, `rst_n_o` rises after exactly edge HOLD_CYC+3, counted from the first edge that samples `man_rst_n_i` high.
- R8: If `supply_min_i` is 0 at an edge, `rst_n_o` is 0 after it and all internal state is cleared. After `supply_min_i` returns high, release takes a full HOLD_CYC edges.
- R9: `rst_o` is always the exact complement of `rst_n_o`.
- R10: Reset stays asserted for as long as a qualified manual request is held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Supply above reset threshold (synchronous) |
| supply_min_i | input | 1 | Supply at least minimally valid |
| man_rst_n_i | input | 1 | Manual reset request, active low, asynchronous |
| rst_n_o | output | 1 | System reset, active low |
| rst_o | output | 1 | System reset, active high |

## Verification
The hardest case to reach is a brownout that lands in the middle of a hold count that is already running. A single-cycle glitch must restart the count rather than simply extend the pulse.

The bench raises the supply flag and waits half a hold period. It then drops the flag for exactly one cycle and measures the release delay from the moment of recovery.

Manual pulses one cycle shorter than the qualification length exercise the boundary of the glitch filter. The bench measures the total latency, including both synchroniser stages, against its own cycle count.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  // Phase of the hold sequencer
  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,  // supply not minimally valid
    PH_HELD  = 2'd1,  // an assert cause is present
    PH_COUNT = 2'd2,  // counting supply-good cycles
    PH_RUN   = 2'd3   // reset released
  } rsq_phase_e;
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int  STAGES    = 2,
  parameter bit  RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic clr,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (clr) chain_q[0] <= RESET_VAL;
          else     chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (clr) chain_q[g] <= RESET_VAL;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rsq_mr_qual.sv
module rsq_mr_qual #(
  parameter int QUAL_CYC = 19
) (
  input  logic clk,
  input  logic clr,
  input  logic mr_s_n,   // synchronised request, active low
  output logic mr_act_o  // qualified request
);
  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);
  localparam logic [CW-1:0] FULL = CW'(QUAL_CYC);

  logic [CW-1:0] low_cnt_q;
  logic          act_q;

  always_ff @(posedge clk) begin
    if (clr || mr_s_n) begin
      low_cnt_q <= '0;
      act_q     <= 1'b0;
    end else begin
      if (low_cnt_q != FULL) low_cnt_q <= low_cnt_q + 1'b1;
      act_q <= act_q | (low_cnt_q == LAST);
    end
  end

  assign mr_act_o = act_q;

  // R5: qualification only follows a sampled low level
  assert_act_after_low_R5: assert property (@(posedge clk) disable iff (clr)
    $rose(act_q) |-> !$past(mr_s_n));
  // R6: counter never passes its qualification length
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (clr)
    low_cnt_q <= FULL);
  // R6: a high sample drops the qualified state
  assert_high_clears_R6: assert property (@(posedge clk) disable iff (clr)
    mr_s_n |=> !act_q);
endmodule

// File: rtl/rsq_hold.sv
module rsq_hold
  import rsq_pkg::*;
#(
  parameter int HOLD_CYC = 25_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok_i,
  input  logic supply_min_i,
  input  logic mr_act_i,
  output logic rst_n_o,
  output logic rst_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] FULL = CW'(HOLD_CYC);

  rsq_phase_e    phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rst_n_q, rst_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (!supply_min_i) begin
      phase_d = PH_OFF;
      cnt_d   = '0;
    end else if (!supply_ok_i || mr_act_i) begin
      phase_d = PH_HELD;
      cnt_d   = '0;
    end else if (phase_q != PH_RUN) begin
      if (cnt_q == LAST) begin
        phase_d = PH_RUN;
        cnt_d   = FULL;
      end else begin
        phase_d = PH_COUNT;
        cnt_d   = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_OFF;
      cnt_q   <= '0;
      rst_n_q <= 1'b0;
      rst_q   <= 1'b1;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      rst_n_q <= (phase_d == PH_RUN);
      rst_q   <= (phase_d != PH_RUN);
    end
  end

  assign rst_n_o = rst_n_q;
  assign rst_o   = rst_q;

  // R2: supply below threshold forces reset on the next edge
  assert_low_supply_R2: assert property (@(posedge clk) disable iff (rst)
    !supply_ok_i |=> !rst_n_q);
  // R3: release only follows a clean supply-good cycle
  assert_release_clean_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_q) |-> ($past(supply_ok_i) && $past(supply_min_i) && !$past(mr_act_i)));
  // R3: hold counter stays within its saturation value
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL);
  // R8: minimally-valid low clears the sequencer
  assert_minvalid_R8: assert property (@(posedge clk) disable iff (rst)
    !supply_min_i |=> (!rst_n_q && phase_q == PH_OFF && cnt_q == '0));
  // R9: outputs are complementary
  assert_complement_R9: assert property (@(posedge clk) disable iff (rst)
    rst_q == !rst_n_q);
  // R10: a qualified manual request keeps reset asserted
  assert_mr_holds_R10: assert property (@(posedge clk) disable iff (rst)
    mr_act_i |=> !rst_n_q);
endmodule

// File: rtl/supply_rst_seq.sv
module supply_rst_seq #(
  parameter int HOLD_CYC    = 25_000_000,
  parameter int MR_QUAL_CYC = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok_i,
  input  logic supply_min_i,
  input  logic man_rst_n_i,
  output logic rst_n_o,
  output logic rst_o
);
  logic front_clr;
  logic mr_s_n;
  logic mr_act;

  assign front_clr = rst | ~supply_min_i;

  rsq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk (clk),
    .clr (front_clr),
    .d_i (man_rst_n_i),
    .q_o (mr_s_n)
  );

  rsq_mr_qual #(.QUAL_CYC(MR_QUAL_CYC)) u_qual (
    .clk      (clk),
    .clr      (front_clr),
    .mr_s_n   (mr_s_n),
    .mr_act_o (mr_act)
  );

  rsq_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk          (clk),
    .rst          (rst),
    .supply_ok_i  (supply_ok_i),
    .supply_min_i (supply_min_i),
    .mr_act_i     (mr_act),
    .rst_n_o      (rst_n_o),
    .rst_o        (rst_o)
  );
endmodule

// File: tb/tb_supply_rst_seq.sv
`timescale 1ns/1ps
module tb_supply_rst_seq;
  localparam int HOLD = 40;
  localparam int QUAL = 6;

  logic clk = 1'b0;
  logic rst, supply_ok, supply_min, man_rst_n;
  logic rst_n_o, rst_o;
  int   n_chk  = 0;
  int   n_fail = 0;

  always #4 clk = ~clk;

  supply_rst_seq #(.HOLD_CYC(HOLD), .MR_QUAL_CYC(QUAL)) dut (
    .clk(clk), .rst(rst), .supply_ok_i(supply_ok), .supply_min_i(supply_min),
    .man_rst_n_i(man_rst_n), .rst_n_o(rst_n_o), .rst_o(rst_o)
  );

  task automatic chk_bit(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts negedges until rst_n_o equals lvl (drive done at previous negedge)
  task automatic wait_lvl(input logic lvl, input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (rst_n_o !== lvl && n < limit);
  endtask

  task automatic t_reset;
    rst = 1'b1; supply_ok = 1'b0; supply_min = 1'b1; man_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_bit("R1 rst_n_o in reset", rst_n_o, 1'b0);
    chk_bit("R1 rst_o in reset", rst_o, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    chk_bit("R1 rst_n_o after reset", rst_n_o, 1'b0);
  endtask

  task automatic t_powerup;
    int n;
    repeat (10) @(negedge clk);
    chk_bit("R2 held while supply low", rst_n_o, 1'b0);
    supply_ok = 1'b1;
    wait_lvl(1'b1, HOLD + 20, n);
    chk_int("R3 power-up release delay", n, HOLD);
    chk_bit("R9 complement released", rst_o, 1'b0);
  endtask

  task automatic t_drop;
    int n;
    supply_ok = 1'b0;
    @(negedge clk);
    chk_bit("R2 immediate assert", rst_n_o, 1'b0);
    chk_bit("R9 complement asserted", rst_o, 1'b1);
    repeat (4) @(negedge clk);
    supply_ok = 1'b1;
    wait_lvl(1'b1, HOLD + 20, n);
    chk_int("R3 release after drop", n, HOLD);
  endtask

  task automatic t_brownout;
    int n;
    supply_ok = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1;
    repeat (HOLD / 2) @(negedge clk);
    chk_bit("R4 still held mid-count", rst_n_o, 1'b0);
    supply_ok = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1;
    wait_lvl(1'b1, 2 * HOLD, n);
    chk_int("R4 count restarted by brownout", n, HOLD);
  endtask

  task automatic t_mr_short;
    int drops = 0;
    man_rst_n = 1'b0;
    repeat (QUAL - 1) @(negedge clk);
    man_rst_n = 1'b1;
    for (int i = 0; i < 3 * QUAL; i++) begin
      @(negedge clk);
      if (rst_n_o !== 1'b1) drops++;
    end
    chk_int("R6 short manual pulse ignored", drops, 0);
  endtask

  task automatic t_mr_long;
    int n;
    int rises = 0;
    man_rst_n = 1'b0;
    wait_lvl(1'b0, 4 * QUAL, n);
    chk_int("R5 manual assert latency", n, QUAL + 3);
    for (int i = 0; i < 2 * HOLD; i++) begin
      @(negedge clk);
      if (rst_n_o !== 1'b0) rises++;
    end
    chk_int("R10 held while request low", rises, 0);
    man_rst_n = 1'b1;
    wait_lvl(1'b1, 2 * HOLD, n);
    chk_int("R7 release after manual request", n, HOLD + 3);
  endtask

  task automatic t_minvalid;
    int n;
    supply_min = 1'b0;
    @(negedge clk);
    chk_bit("R8 forced by minimally-valid low", rst_n_o, 1'b0);
    chk_bit("R9 complement under min low", rst_o, 1'b1);
    repeat (3) @(negedge clk);
    supply_min = 1'b1;
    wait_lvl(1'b1, 2 * HOLD, n);
    chk_int("R8 full hold after min restore", n, HOLD);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_drop();
    t_brownout();
    t_mr_short();
    t_mr_long();
    t_minvalid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule